// File: doc/BRIEF.md
# Fetch-Stage Branch Target Buffer

This block is a small fully associative table that predicts branches in the fetch stage. It is searched with the current fetch PC in the same cycle as the instruction-memory read. On a hit it returns the stored target, a taken or not-taken guess, whether the target lies below the branch address, and whether the branch is unconditional. The block also computes the next fetch PC: the stored target when the hit predicts taken, otherwise PC+4. A miss makes no prediction, so unknown branches behave as not taken.

When a branch resolves in execute, the pipeline presents its PC, actual direction, actual target and kind on the update port. The block compares this outcome with what the table currently predicts for that PC. It raises a flush request together with the correct PC when the two disagree. On the next clock edge it refreshes the matching entry. If there is no matching entry and the branch was taken, it allocates a new one. An empty slot is used first. When the table is full, slots are replaced in round-robin order.

Top module: `btb_predictor`

## Requirements
- R1: After reset every entry is invalid, so any fetch PC misses.
- R2: On a lookup miss, pred_hit and pred_taken are 0 and next_pc equals fetch_pc + 4.
- R3: A resolved not-taken branch that misses in the table allocates nothing. A later lookup of that PC still misses.
- R4: A resolved taken branch that misses allocates an entry at the next clock edge. A later lookup of that PC hits with pred_taken = 1, pred_target equal to the resolved target and next_pc equal to that target. No two valid entries hold the same PC.
- R5: On a hit, pred_uncond repeats the stored kind (1 = unconditional) and pred_backward is 1 exactly when the stored target is numerically below the branch PC.
- R6: An update that hits rewrites the entry's target and its one-bit taken history with the resolved values. After a not-taken resolution the entry still hits but predicts not taken, with next_pc = PC+4.
- R7: When the current prediction for upd_pc is not taken (miss, or hit with history 0) and the branch resolves taken, flush is 1 and redirect_pc equals upd_target in the same cycle.
- R8: When the prediction is taken and the branch resolves not taken, flush is 1 and redirect_pc equals upd_pc + 4.
- R9: When the prediction is taken and the branch resolves taken with a target that differs from the stored one, flush is 1 and redirect_pc equals upd_target.
- R10: When the resolved direction matches the prediction (and, if taken, the target also matches), flush is 0.
- R11: When a lookup and an update of the same PC fall in the same cycle, the lookup returns the entry as it stood before the update. The change is visible from the next cycle.
- R12: With all 16 entries valid, each new allocation replaces slots in round-robin order, starting at slot 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | PC_W | PC of the instruction being fetched |
| pred_hit | output | 1 | fetch_pc matches a valid entry |
| pred_taken | output | 1 | Hit and stored history says taken |
| pred_target | output | PC_W | Stored target on a hit, zero otherwise |
| pred_backward | output | 1 | Hit and stored target is below the branch PC |
| pred_uncond | output | 1 | Hit and entry is an unconditional branch |
| next_pc | output | PC_W | Predicted next fetch address |
| upd_valid | input | 1 | A branch resolution is presented |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Actual direction |
| upd_target | input | PC_W | Actual target address |
| upd_uncond | input | 1 | Branch is unconditional |
| flush | output | 1 | Prediction was wrong; discard younger instructions |
| redirect_pc | output | PC_W | Correct PC when flush is 1 |

## Verification
The hardest state to reach from the ports is a full table whose round-robin pointer has already moved. Reaching it takes sixteen taken resolutions of distinct PCs before any replacement can happen. The bench drives a run of seventeen and then eighteen distinct taken branches after a fresh reset. After each replacement it probes the oldest surviving PCs through the fetch port to see which slot was evicted. Same-cycle lookup and update of one PC is reached by presenting both in the same vector, so the old entry must still be visible.

// File: rtl/btb_pkg.sv
package btb_pkg;
  localparam int INSTR_BYTES = 4;

  typedef enum logic {
    BR_COND   = 1'b0,
    BR_UNCOND = 1'b1
  } br_kind_e;
endpackage

// File: rtl/btb_match.sv
module btb_match #(
  parameter int PC_W    = 32,
  parameter int ENTRIES = 16,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES*PC_W-1:0] tags_flat,
  input  logic [ENTRIES-1:0]      valid_vec,
  input  logic [PC_W-1:0]         key,
  output logic [ENTRIES-1:0]      match_vec,
  output logic                    hit,
  output logic [IDX_W-1:0]        idx
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_vec[g] = valid_vec[g] && (tags_flat[g*PC_W +: PC_W] == key);
  end

  assign hit = |match_vec;

  always_comb begin
    idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match_vec[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/btb_victim.sv
module btb_victim #(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic [IDX_W-1:0]   rr_ptr,
  output logic [IDX_W-1:0]   victim,
  output logic               use_rr
);
  logic [IDX_W-1:0] first_free;

  always_comb begin
    first_free = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) first_free = IDX_W'(i);
    end
  end

  assign use_rr = &valid_vec;
  assign victim = use_rr ? rr_ptr : first_free;
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
  import btb_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int ENTRIES = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] fetch_pc,
  output logic            pred_hit,
  output logic            pred_taken,
  output logic [PC_W-1:0] pred_target,
  output logic            pred_backward,
  output logic            pred_uncond,
  output logic [PC_W-1:0] next_pc,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic [PC_W-1:0] upd_target,
  input  logic            upd_uncond,
  output logic            flush,
  output logic [PC_W-1:0] redirect_pc
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  typedef struct packed {
    logic            valid;
    logic [PC_W-1:0] tag;
    logic [PC_W-1:0] target;
    logic            hist;
    br_kind_e        kind;
    logic            backward;
  } entry_t;

  function automatic logic [PC_W-1:0] seq_pc(input logic [PC_W-1:0] pc);
    return pc + PC_W'(INSTR_BYTES);
  endfunction

  function automatic logic points_back(input logic [PC_W-1:0] pc,
                                       input logic [PC_W-1:0] tgt);
    return tgt < pc;
  endfunction

  entry_t                  tbl [ENTRIES];
  logic [ENTRIES-1:0]      valid_vec;
  logic [ENTRIES*PC_W-1:0] tags_flat;
  logic [IDX_W-1:0]        rr_ptr;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_flat
    assign valid_vec[g]              = tbl[g].valid;
    assign tags_flat[g*PC_W +: PC_W] = tbl[g].tag;
  end

  // fetch-side search
  logic [ENTRIES-1:0] fetch_match;
  logic               fetch_hit;
  logic [IDX_W-1:0]   fetch_idx;

  btb_match #(.PC_W(PC_W), .ENTRIES(ENTRIES)) u_fetch_cam (
    .tags_flat (tags_flat),
    .valid_vec (valid_vec),
    .key       (fetch_pc),
    .match_vec (fetch_match),
    .hit       (fetch_hit),
    .idx       (fetch_idx)
  );

  // resolve-side search
  logic [ENTRIES-1:0] upd_match;
  logic               upd_hit;
  logic [IDX_W-1:0]   upd_idx;

  btb_match #(.PC_W(PC_W), .ENTRIES(ENTRIES)) u_upd_cam (
    .tags_flat (tags_flat),
    .valid_vec (valid_vec),
    .key       (upd_pc),
    .match_vec (upd_match),
    .hit       (upd_hit),
    .idx       (upd_idx)
  );

  logic [IDX_W-1:0] victim;
  logic             use_rr;

  btb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .valid_vec (valid_vec),
    .rr_ptr    (rr_ptr),
    .victim    (victim),
    .use_rr    (use_rr)
  );

  // prediction outputs
  entry_t fe;
  assign fe            = tbl[fetch_idx];
  assign pred_hit      = fetch_hit;
  assign pred_taken    = fetch_hit && fe.hist;
  assign pred_target   = fetch_hit ? fe.target : '0;
  assign pred_backward = fetch_hit && fe.backward;
  assign pred_uncond   = fetch_hit && (fe.kind == BR_UNCOND);
  assign next_pc       = pred_taken ? fe.target : seq_pc(fetch_pc);

  // misprediction detection
  entry_t ue;
  logic   upd_pred_taken;
  logic   dir_wrong;
  logic   tgt_wrong;
  logic   alloc_fire;

  assign ue             = tbl[upd_idx];
  assign upd_pred_taken = upd_hit && ue.hist;
  assign dir_wrong      = upd_taken != upd_pred_taken;
  assign tgt_wrong      = upd_taken && upd_pred_taken && (ue.target != upd_target);
  assign flush          = upd_valid && (dir_wrong || tgt_wrong);
  assign redirect_pc    = upd_taken ? upd_target : seq_pc(upd_pc);
  assign alloc_fire     = upd_valid && !upd_hit && upd_taken;

  // table write
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) tbl[i] <= '0;
      rr_ptr <= '0;
    end else if (upd_valid) begin
      if (upd_hit) begin
        tbl[upd_idx].target   <= upd_target;
        tbl[upd_idx].hist     <= upd_taken;
        tbl[upd_idx].kind     <= br_kind_e'(upd_uncond);
        tbl[upd_idx].backward <= points_back(upd_pc, upd_target);
      end else if (alloc_fire) begin
        tbl[victim].valid    <= 1'b1;
        tbl[victim].tag      <= upd_pc;
        tbl[victim].target   <= upd_target;
        tbl[victim].hist     <= 1'b1;
        tbl[victim].kind     <= br_kind_e'(upd_uncond);
        tbl[victim].backward <= points_back(upd_pc, upd_target);
        if (use_rr)
          rr_ptr <= (rr_ptr == IDX_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/btb_checker.sv
module btb_checker #(
  parameter int PC_W    = 32,
  parameter int ENTRIES = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               upd_valid,
  input logic [PC_W-1:0]    upd_pc,
  input logic               upd_taken,
  input logic [PC_W-1:0]    upd_target,
  input logic               upd_hit,
  input logic               flush,
  input logic [PC_W-1:0]    redirect_pc,
  input logic [ENTRIES-1:0] valid_vec,
  input logic [ENTRIES-1:0] fetch_match
);
  // R4
  alloc_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_taken && !upd_hit && !(&valid_vec))
    |=> ($countones(valid_vec) == $countones($past(valid_vec)) + 1));

  // R3
  nt_no_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_taken && !upd_hit) |=> (valid_vec == $past(valid_vec)));

  // R4
  unique_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fetch_match));

  // R8
  nt_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !upd_taken) |-> (redirect_pc == upd_pc + PC_W'(4)));

  // R9
  tk_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && upd_taken) |-> (redirect_pc == upd_target));
endmodule

bind btb_predictor btb_checker #(.PC_W(PC_W), .ENTRIES(ENTRIES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .upd_valid   (upd_valid),
  .upd_pc      (upd_pc),
  .upd_taken   (upd_taken),
  .upd_target  (upd_target),
  .upd_hit     (upd_hit),
  .flush       (flush),
  .redirect_pc (redirect_pc),
  .valid_vec   (valid_vec),
  .fetch_match (fetch_match)
);

// File: tb/sim_btb_predictor.sv
`timescale 1ns/1ps
module sim_btb_predictor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic        pred_hit, pred_taken, pred_backward, pred_uncond, flush;
  logic [31:0] pred_target, next_pc, redirect_pc;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic        upd_taken = 1'b0;
  logic [31:0] upd_target = '0;
  logic        upd_uncond = 1'b0;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  btb_predictor u0 (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
    .pred_hit(pred_hit), .pred_taken(pred_taken), .pred_target(pred_target),
    .pred_backward(pred_backward), .pred_uncond(pred_uncond), .next_pc(next_pc),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_target(upd_target), .upd_uncond(upd_uncond),
    .flush(flush), .redirect_pc(redirect_pc)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic        uv;
    logic [31:0] upc;
    logic        ut;
    logic [31:0] utg;
    logic        uunc;
    logic        ef;
    logic [31:0] er;
    logic [31:0] fpc;
    logic        eh;
    logic        et;
    logic [31:0] en;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    // R2 miss after reset
    '{1'b0, 32'h0,   1'b0, 32'h0,   1'b0, 1'b0, 32'h0,   32'h100, 1'b0, 1'b0, 32'h104},
    // R3 / R10 not-taken on miss: no flush
    '{1'b1, 32'h100, 1'b0, 32'h200, 1'b0, 1'b0, 32'h0,   32'h100, 1'b0, 1'b0, 32'h104},
    // R7 taken on miss; R3 still miss; R11 old state seen
    '{1'b1, 32'h100, 1'b1, 32'h200, 1'b0, 1'b1, 32'h200, 32'h100, 1'b0, 1'b0, 32'h104},
    // R4 allocated entry hits
    '{1'b0, 32'h0,   1'b0, 32'h0,   1'b0, 1'b0, 32'h0,   32'h100, 1'b1, 1'b1, 32'h200},
    // R10 correct taken prediction
    '{1'b1, 32'h100, 1'b1, 32'h200, 1'b0, 1'b0, 32'h0,   32'h100, 1'b1, 1'b1, 32'h200},
    // R9 wrong target; R11 old target still seen
    '{1'b1, 32'h100, 1'b1, 32'h300, 1'b0, 1'b1, 32'h300, 32'h100, 1'b1, 1'b1, 32'h200},
    // R8 taken predicted, not taken; R6 new target visible
    '{1'b1, 32'h100, 1'b0, 32'h300, 1'b0, 1'b1, 32'h104, 32'h100, 1'b1, 1'b1, 32'h300},
    // R6 history now not taken
    '{1'b0, 32'h0,   1'b0, 32'h0,   1'b0, 1'b0, 32'h0,   32'h100, 1'b1, 1'b0, 32'h104},
    // R7 hit predicting not taken resolves taken
    '{1'b1, 32'h100, 1'b1, 32'h300, 1'b0, 1'b1, 32'h300, 32'h100, 1'b1, 1'b0, 32'h104}
  };

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; upd_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic resolve(input logic [31:0] pc, input logic t, input logic [31:0] tg,
                         input logic unc);
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = pc; upd_taken = t; upd_target = tg; upd_uncond = unc;
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic probe(input string req, input logic [31:0] pc, input logic eh);
    fetch_pc = pc;
    #1;
    chk(req, {31'b0, pred_hit}, {31'b0, eh});
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    @(negedge clk);
    fetch_pc = 32'h100; #1;
    chk("R1 hit after reset", {31'b0, pred_hit}, 32'h0);
    chk("R1 flush after reset", {31'b0, flush}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      upd_valid = VECS[i].uv; upd_pc = VECS[i].upc; upd_taken = VECS[i].ut;
      upd_target = VECS[i].utg; upd_uncond = VECS[i].uunc; fetch_pc = VECS[i].fpc;
      #1;
      chk($sformatf("R7-R10 flush vec%0d", i), {31'b0, flush}, {31'b0, VECS[i].ef});
      if (VECS[i].ef) chk($sformatf("R7-R9 redirect vec%0d", i), redirect_pc, VECS[i].er);
      chk($sformatf("R2/R4 hit vec%0d", i), {31'b0, pred_hit}, {31'b0, VECS[i].eh});
      chk($sformatf("R6 taken vec%0d", i), {31'b0, pred_taken}, {31'b0, VECS[i].et});
      chk($sformatf("R2/R4 next_pc vec%0d", i), next_pc, VECS[i].en);
    end
    @(negedge clk);
    upd_valid = 1'b0;

    // R5 backward unconditional, forward conditional
    resolve(32'h400, 1'b1, 32'h380, 1'b1);
    fetch_pc = 32'h400; #1;
    chk("R5 backward", {31'b0, pred_backward}, 32'h1);
    chk("R5 uncond", {31'b0, pred_uncond}, 32'h1);
    chk("R4 target", pred_target, 32'h380);
    fetch_pc = 32'h100; #1;
    chk("R5 forward", {31'b0, pred_backward}, 32'h0);
    chk("R5 cond", {31'b0, pred_uncond}, 32'h0);

    // R1 reset clears table
    do_reset();
    @(negedge clk);
    probe("R1 cleared 0x400", 32'h400, 1'b0);

    // R12 round-robin replacement
    for (int i = 0; i < 16; i++) resolve(32'h1000 + 32'(i) * 16, 1'b1, 32'h2000, 1'b0);
    for (int i = 0; i < 16; i++) probe("R12 fill hit", 32'h1000 + 32'(i) * 16, 1'b1);
    resolve(32'h1100, 1'b1, 32'h2000, 1'b0);
    probe("R12 slot0 evicted", 32'h1000, 1'b0);
    probe("R12 slot1 kept", 32'h1010, 1'b1);
    probe("R12 newcomer", 32'h1100, 1'b1);
    resolve(32'h1110, 1'b1, 32'h2000, 1'b0);
    probe("R12 slot1 evicted", 32'h1010, 1'b0);
    probe("R12 slot2 kept", 32'h1020, 1'b1);
    probe("R12 first newcomer kept", 32'h1100, 1'b1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule